// File: doc/BRIEF.md
# Equality-Triggered Watchdog Counter

This block is a watchdog timer built around a 32-bit counter that advances on every bus clock and never stops. Software sets a limit value. When the counter lands exactly on that limit while the watchdog is armed, the block raises a one-cycle reset request. A system-level permit input then gates that request onto the final reset output. Because the counter is neither reloaded nor halted at the limit, a counter that has already passed the limit has to wrap through the whole 32-bit range before it can match again.

Software reaches the block through a small register bus: an address, a write strobe, write data and registered read data. There are three word registers. Writing the limit also clears the counter, so programming a new timeout restarts the count. Software keeps the watchdog quiet by writing the limit again, or by loading the counter directly. Clearing the arm bit only hides the reset request; the counter keeps running.

Top module: `wdog_timer`

## Requirements
- R1: After the synchronous reset, the limit register holds 0xFFFFFFFF, the control register holds 0 and the counter holds 0. Both `wd_req` and `wd_rst` are low.
- R2: The counter increases by one on every clock edge that carries no bus write to it, and it wraps from 0xFFFFFFFF to 0.
- R3: A write to the limit register (offset 0xD0) stores the data and sets the counter to 0 on the same edge.
- R4: A write to the count register (offset 0xD8) loads the counter with the written data in place of the increment.
- R5: `wd_req` is high for exactly the one cycle that follows a cycle in which the counter equals the limit while the arm bit is set.
- R6: No request is raised while the counter is above the limit. The counter continues past the limit without any reload.
- R7: The arm bit is bit 0 of the control register (offset 0xD4), where 1 means armed. While it is 0 no request is raised, but the counter still counts.
- R8: Control bits 31 to 1 always read as 0. Writing ones to them has no effect.
- R9: `wd_rst` is high only when `wd_req` is high and `sys_rst_en` is high.
- R10: `bus_rdata` is registered. It shows, one edge later, the register at the address presented before that edge. Any address other than the three registers reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sys_rst_en | input | 1 | System permit for the reset output |
| wd_req | output | 1 | One-cycle reset request pulse |
| wd_rst | output | 1 | Gated reset output |

## Verification
The assertions check several rules on every cycle. A request follows every armed match, and no request appears without one. The counter steps by one whenever no write came in, and it is zero after a limit write. A disarmed cycle is never followed by a request, and the reserved control bits read as zero. Other behaviour can only be shown by the bench's scenarios. These are the exact edge on which the pulse appears for each programmed limit, and the silent pass of a counter loaded beyond the limit. They also cover the wrap through zero that leads to a later match and the gating by `sys_rst_en`.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned WD_DATA_W = 32;
  localparam int unsigned WD_ADDR_W = 8;
  localparam logic [WD_ADDR_W-1:0] OFS_LIMIT = 8'hD0;
  localparam logic [WD_ADDR_W-1:0] OFS_CTRL  = 8'hD4;
  localparam logic [WD_ADDR_W-1:0] OFS_COUNT = 8'hD8;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_LIMIT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_COUNT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W = WD_DATA_W,
  parameter int unsigned ADDR_W = WD_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] cnt,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] limit,
  output logic              arm,
  output logic              limit_wr,
  output logic              count_wr
);
  reg_sel_e sel;

  always_comb begin
    if (bus_addr == ADDR_W'(OFS_LIMIT))      sel = SEL_LIMIT;
    else if (bus_addr == ADDR_W'(OFS_CTRL))  sel = SEL_CTRL;
    else if (bus_addr == ADDR_W'(OFS_COUNT)) sel = SEL_COUNT;
    else                                     sel = SEL_NONE;
  end

  assign limit_wr = bus_we && (sel == SEL_LIMIT);
  assign count_wr = bus_we && (sel == SEL_COUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      limit <= '1;
      arm   <= 1'b0;
    end else begin
      if (limit_wr) limit <= bus_wdata;
      if (bus_we && sel == SEL_CTRL) arm <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      unique case (sel)
        SEL_LIMIT: bus_rdata <= limit;
        SEL_CTRL:  bus_rdata <= {{(DATA_W-1){1'b0}}, arm};
        SEL_COUNT: bus_rdata <= cnt;
        default:   bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (load)  cnt <= load_val;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdog_match.sv
module wdog_match #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] cnt,
  input  logic [DATA_W-1:0] limit,
  input  logic              arm,
  output logic              req
);
  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= arm && (cnt == limit);
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W = WD_DATA_W,
  parameter int unsigned ADDR_W = WD_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sys_rst_en,
  output logic              wd_req,
  output logic              wd_rst
);
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] limit_q;
  logic              arm_q;
  logic              limit_wr;
  logic              count_wr;

  wdog_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .cnt(cnt_q), .bus_rdata(bus_rdata),
    .limit(limit_q), .arm(arm_q),
    .limit_wr(limit_wr), .count_wr(count_wr)
  );

  wdog_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst),
    .clr(limit_wr), .load(count_wr), .load_val(bus_wdata),
    .cnt(cnt_q)
  );

  wdog_match #(.DATA_W(DATA_W)) u_match (
    .clk(clk), .rst(rst),
    .cnt(cnt_q), .limit(limit_q), .arm(arm_q),
    .req(wd_req)
  );

  assign wd_rst = wd_req && sys_rst_en;
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W = WD_DATA_W,
  parameter int unsigned ADDR_W = WD_ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] limit_q,
  input logic              arm_q,
  input logic              wd_req
);
  AST_REQ_AFTER_MATCH: assert property (@(posedge clk) disable iff (rst)
    (arm_q && cnt_q == limit_q) |=> wd_req); // R5

  AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && wd_req) |-> $past(arm_q && cnt_q == limit_q)); // R5

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_we)) |-> cnt_q == $past(cnt_q) + 1'b1); // R2

  AST_LIMIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_we && bus_addr == ADDR_W'(OFS_LIMIT))) |-> cnt_q == '0); // R3

  AST_DISARM_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(arm_q)) |-> !wd_req); // R7

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_addr == ADDR_W'(OFS_CTRL))) |-> bus_rdata[DATA_W-1:1] == '0); // R8
endmodule

bind wdog_timer wdog_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_wdog_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_rdata(bus_rdata), .cnt_q(cnt_q), .limit_q(limit_q),
  .arm_q(arm_q), .wd_req(wd_req)
);

// File: tb/test_wdog_timer.sv
module test_wdog_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sys_rst_en = 1'b0;
  logic        wd_req;
  logic        wd_rst;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [7:0] A_LIM = 8'hD0, A_CTL = 8'hD4, A_CNT = 8'hD8;

  // {limit, arm, sys_rst_en}
  localparam logic [33:0] VEC [0:5] = '{
    {32'd3,  1'b1, 1'b1},
    {32'd5,  1'b1, 1'b0},
    {32'd0,  1'b1, 1'b1},
    {32'd7,  1'b0, 1'b1},
    {32'd1,  1'b1, 1'b1},
    {32'd10, 1'b1, 1'b1}
  };

  always #5 clk = ~clk;

  wdog_timer i_wdog_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_rst_en(sys_rst_en),
    .wd_req(wd_req), .wd_rst(wd_rst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // samples after edges 1..win following the last write; pulse expected after edge hit
  task automatic observe(input int win, input int hit, input bit sys_en, input string req);
    for (int i = 1; i <= win; i++) begin
      @(negedge clk);
      chk(req, {31'd0, wd_req}, {31'd0, (i == hit)});
      chk("R9", {31'd0, wd_rst}, {31'd0, (i == hit) && sys_en});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    chk("R1", {31'd0, wd_req}, 32'd0);
    chk("R1", {31'd0, wd_rst}, 32'd0);
    rst = 1'b0;
    // counter was 0 at release; the read captures it one edge later
    rd(A_CNT, d); chk("R1", d, 32'd1);
    rd(A_LIM, d); chk("R1", d, 32'hFFFFFFFF);
    rd(A_CTL, d); chk("R1", d, 32'd0);
    rd(8'hDC, d); chk("R10", d, 32'd0);
    rd(8'h00, d); chk("R10", d, 32'd0);

    // R8: reserved control bits
    wr(A_CTL, 32'hFFFFFFFE);
    rd(A_CTL, d); chk("R8", d, 32'd0);
    wr(A_CTL, 32'hFFFFFFFF);
    rd(A_CTL, d); chk("R8", d, 32'd1);

    // table of limit / arm / permit vectors (R3, R5, R7, R9)
    for (int v = 0; v < 6; v++) begin
      logic [31:0] lim;
      bit en, se;
      lim = VEC[v][33:2]; en = VEC[v][1]; se = VEC[v][0];
      sys_rst_en = se;
      wr(A_CTL, {31'd0, en});
      wr(A_LIM, lim);
      observe(int'(lim) + 4, en ? int'(lim) + 1 : -1, se, en ? "R5" : "R7");
    end

    // R4: count load and read back
    sys_rst_en = 1'b1;
    wr(A_CNT, 32'h0000_1234);
    rd(A_CNT, d); chk("R4", d, 32'h0000_1235);

    // R3: limit write clears count
    wr(A_LIM, 32'd1000);
    rd(A_CNT, d); chk("R3", d, 32'd1);

    // R7: disarmed, counting continues
    wr(A_CTL, 32'd0);
    wr(A_LIM, 32'd4);
    observe(8, -1, 1'b1, "R7");
    rd(A_CNT, d); chk("R7", d, 32'd9);

    // R6: counter loaded above the limit never fires
    wr(A_CTL, 32'd1);
    wr(A_LIM, 32'd5);
    wr(A_CNT, 32'd6);
    observe(20, -1, 1'b1, "R6");

    // R2: wrap through zero then match at limit 2
    wr(A_LIM, 32'd2);
    wr(A_CNT, 32'hFFFFFFFE);
    observe(8, 5, 1'b1, "R2");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule